// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock for a serial audio port. Both clocks come from a root audio clock. Two settings shape the frame. The first sets how many root-clock cycles make up one frame: 256, 384, 512 or 768. The second sets how many bit clocks make up one frame: 16, 24, 32 or 48. The block divides the first by the second to get the root-to-bit divide. Combinations that do not give an even whole number raise an error flag and hold the clocks idle.

The root clock is either the block's own clock or a slower pin input. The pin input is synchronised, and each rising edge counts as one root tick. In master mode the block drives both clocks and turns on the pad output enables. In slave mode it turns the enables off and passes synchronised copies of the external bit and frame clocks to its outputs. In both modes it gives the serializer a single-cycle strobe at each rising and each falling bit-clock edge. A ratio written while master clocks run takes effect at the next frame boundary.

Top module: `acg_clkgen`

## Requirements
- R1: Frame code 0, 1, 2, 3 selects 256, 384, 512, 768 root cycles per frame, and the bit-clock period is that length divided by the bits per frame, in root cycles.
- R2: Frame codes 4 to 7 select 256 root cycles per frame.
- R3: Bit code 0, 1, 2, 3 selects 16, 24, 32, 48 bit clocks per frame, and the frame clock stays in each level for half that many bit clocks.
- R4: Bit codes 4 to 7 are ignored; the last valid bit setting stays in force.
- R5: When the divide is not an even whole number, `cfg_err` is 1 and, once loaded, the bit clock, the frame clock and both strobes stay low. A legal setting gives `cfg_err` 0.
- R6: In master mode both output enables are 1. In slave mode they are 0, and `bclk_o`/`lrclk_o` follow `bclk_in`/`lrclk_in` two clock edges later.
- R7: With the external root selected, one root tick is counted per rising edge of `rclk_ext_in`, so the bit-clock period is the divide times the external period.
- R8: A ratio change made while master clocks run keeps the old bit-clock period until the frame clock next falls from 1 to 0, and uses the new one after that.
- R9: `bclk_rise` is a one-cycle pulse in the cycle `bclk_o` goes 0 to 1. `bclk_fall` is the same for 1 to 0. The two are never high together.
- R10: In reset, and while `enable` is 0, `bclk_o`, `lrclk_o`, `bclk_rise` and `bclk_fall` are 0.
- R11: In master mode `lrclk_o` changes only in a cycle where `bclk_fall` is 1. A frame starts with `lrclk_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal root clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the clock outputs |
| master | input | 1 | 1: drive clocks, 0: follow external clocks |
| rclk_ext_sel | input | 1 | 1: root ticks come from `rclk_ext_in` |
| rclk_ext_in | input | 1 | External root clock pin, sampled |
| frame_code | input | 3 | Root cycles per frame selector |
| bpf_code | input | 3 | Bit clocks per frame selector |
| bclk_in | input | 1 | External bit clock (slave) |
| lrclk_in | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock, 0 = first half of frame |
| bclk_oe | output | 1 | Pad enable for the bit clock |
| lrclk_oe | output | 1 | Pad enable for the frame clock |
| bclk_rise | output | 1 | Strobe at a bit-clock rising edge |
| bclk_fall | output | 1 | Strobe at a bit-clock falling edge |
| cfg_err | output | 1 | Selected ratio pair is not usable |

## Verification
A wrong divide counter or a wrong decoded ratio shows at the first measured bit-clock period after enable. That is within two bit periods. A wrong bit counter shows in the frame-clock half period, which can take up to a frame. A config register that reloads at the wrong time shows within one frame of a change made while running: the period changes early, or late. Sync depth errors in slave mode show as an output edge one cycle off from the expected two-edge delay.

// File: rtl/acg_pkg.sv
// Shared settings and ratio arithmetic for the audio clock generator.
// Assumes the frame length and bits-per-frame sets are fixed and small.
package acg_pkg;
    parameter int CODE_W = 3;
    parameter int DIV_W  = 6;
    parameter int BIT_W  = 5;

    typedef logic [1:0] sel_t;

    // Root cycles per frame for a decoded selector.
    function automatic int frame_len(input sel_t s);
        case (s)
            2'd1:    return 384;
            2'd2:    return 512;
            2'd3:    return 768;
            default: return 256;
        endcase
    endfunction

    // Bit clocks per frame for a decoded selector.
    function automatic int bits_len(input sel_t s);
        case (s)
            2'd0:    return 16;
            2'd1:    return 24;
            2'd3:    return 48;
            default: return 32;
        endcase
    endfunction

    // A pair is usable when it divides to an even whole number.
    function automatic logic ratio_ok(input sel_t f, input sel_t b);
        int fl, bl;
        fl = frame_len(f);
        bl = bits_len(b);
        return ((fl % bl) == 0) && (((fl / bl) % 2) == 0);
    endfunction
endpackage

// File: rtl/acg_cfg.sv
// Ratio configuration: captures selector codes into pending registers
// and moves them to the active set only when told to by load_i.
// Assumes load_i is high whenever the master counters are idle.
module acg_cfg
    import acg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] frame_code_i,
    input  logic [CODE_W-1:0] bpf_code_i,
    input  logic              load_i,
    output logic [DIV_W-1:0]  half_div_o,
    output logic [BIT_W-1:0]  half_bits_o,
    output logic              act_ok_o,
    output logic              err_o
);
    sel_t pend_f, pend_b, act_f, act_b;

    // Pending capture: bad frame codes fall back, bad bit codes are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_f <= 2'd0;
            pend_b <= 2'd2;
        end else begin
            pend_f <= (frame_code_i < CODE_W'(4)) ? sel_t'(frame_code_i) : 2'd0;
            if (bpf_code_i < CODE_W'(4))
                pend_b <= sel_t'(bpf_code_i);
        end
    end

    // Active set: reloaded only at a frame boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_f <= 2'd0;
            act_b <= 2'd2;
        end else if (load_i) begin
            act_f <= pend_f;
            act_b <= pend_b;
        end
    end

    // Derived divide values of the active set.
    always_comb begin
        act_ok_o    = ratio_ok(act_f, act_b);
        half_div_o  = act_ok_o ? DIV_W'(frame_len(act_f) / bits_len(act_b) / 2) : DIV_W'(1);
        half_bits_o = BIT_W'(bits_len(act_b) / 2);
        err_o       = !ratio_ok(pend_f, pend_b);
    end

    p_fallback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_code_i >= CODE_W'(4)) |=> (pend_f == 2'd0));
    p_keep_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bpf_code_i >= CODE_W'(4)) |=> $stable(pend_b));
    p_hold_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(act_f) && $stable(act_b)));
endmodule

// File: rtl/acg_tick.sv
// Root tick source: every cycle for the internal root, or one tick per
// synchronised rising edge of the external root pin.
// Assumes the external root runs below half the block clock rate.
module acg_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel_i,
    input  logic ext_in_i,
    output logic tick_o
);
    logic [2:0] sync_q;

    // Synchroniser and edge history for the external root pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_in_i};
    end

    // Tick selection.
    always_comb tick_o = ext_sel_i ? (sync_q[1] && !sync_q[2]) : 1'b1;
endmodule

// File: rtl/acg_master.sv
// Master clock divider: bit clock from root ticks, frame clock from
// bit-clock falling edges, plus edge strobes and a frame-end marker.
// Assumes half_div_i >= 1 and that divide values change only at frame end.
module acg_master
    import acg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic [BIT_W-1:0] half_bits_i,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             frame_end_o
);
    logic [DIV_W-1:0] div_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic             bclk_q, lr_q, rise_q, fall_q;
    logic             wrap, bit_wrap;

    // Divider and bit-count wrap points.
    always_comb begin
        wrap        = tick_i && (div_cnt == half_div_i - DIV_W'(1));
        bit_wrap    = (bit_cnt == half_bits_i - BIT_W'(1));
        frame_end_o = run_i && wrap && bclk_q && bit_wrap && lr_q;
    end

    // Counter, clock and strobe state.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            bclk_q  <= 1'b0;
            lr_q    <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            rise_q <= wrap && !bclk_q;
            fall_q <= wrap && bclk_q;
            if (wrap) begin
                div_cnt <= '0;
                bclk_q  <= !bclk_q;
                if (bclk_q) begin
                    if (bit_wrap) begin
                        bit_cnt <= '0;
                        lr_q    <= !lr_q;
                    end else begin
                        bit_cnt <= bit_cnt + BIT_W'(1);
                    end
                end
            end else if (tick_i) begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    assign bclk_o  = bclk_q;
    assign lrclk_o = lr_q;
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;

    p_rise_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (bclk_q && !$past(bclk_q)));
    p_lr_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_q != $past(lr_q)) |-> fall_q);
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!bclk_q && !lr_q && !rise_q && !fall_q));
endmodule

// File: rtl/acg_slave.sv
// Slave follower: synchronises external bit and frame clocks and makes
// bit-clock edge strobes. Assumes external clocks are slower than clk/2.
module acg_slave (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic bclk_in_i,
    input  logic lrclk_in_i,
    output logic bclk_o,
    output logic lrclk_o,
    output logic rise_o,
    output logic fall_o
);
    logic [2:0] b_q;
    logic [1:0] l_q;

    // Two-stage sync plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            b_q <= '0;
            l_q <= '0;
        end else begin
            b_q <= {b_q[1:0], bclk_in_i};
            l_q <= {l_q[0], lrclk_in_i};
        end
    end

    // Outputs and edge strobes.
    always_comb begin
        bclk_o  = b_q[1];
        lrclk_o = l_q[1];
        rise_o  = b_q[1] && !b_q[2];
        fall_o  = !b_q[1] && b_q[2];
    end
endmodule

// File: rtl/acg_clkgen.sv
// Audio serial clock generator top: config, root tick, master divider
// and slave follower, with the mode selecting which drives the outputs.
// Assumes mode and root source change only while enable is 0.
module acg_clkgen
    import acg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              master,
    input  logic              rclk_ext_sel,
    input  logic              rclk_ext_in,
    input  logic [CODE_W-1:0] frame_code,
    input  logic [CODE_W-1:0] bpf_code,
    input  logic              bclk_in,
    input  logic              lrclk_in,
    output logic              bclk_o,
    output logic              lrclk_o,
    output logic              bclk_oe,
    output logic              lrclk_oe,
    output logic              bclk_rise,
    output logic              bclk_fall,
    output logic              cfg_err
);
    logic [DIV_W-1:0] half_div;
    logic [BIT_W-1:0] half_bits;
    logic act_ok, tick, frame_end, m_run, load;
    logic m_bclk, m_lr, m_rise, m_fall;
    logic s_bclk, s_lr, s_rise, s_fall;

    // Run and reload control.
    always_comb begin
        m_run = enable && master && act_ok;
        load  = !(enable && master) || !act_ok || frame_end;
    end

    acg_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .frame_code_i(frame_code), .bpf_code_i(bpf_code),
        .load_i(load), .half_div_o(half_div), .half_bits_o(half_bits),
        .act_ok_o(act_ok), .err_o(cfg_err)
    );

    acg_tick u_tick (
        .clk(clk), .rst_n(rst_n), .ext_sel_i(rclk_ext_sel),
        .ext_in_i(rclk_ext_in), .tick_o(tick)
    );

    acg_master u_master (
        .clk(clk), .rst_n(rst_n), .run_i(m_run), .tick_i(tick),
        .half_div_i(half_div), .half_bits_i(half_bits),
        .bclk_o(m_bclk), .lrclk_o(m_lr), .rise_o(m_rise), .fall_o(m_fall),
        .frame_end_o(frame_end)
    );

    acg_slave u_slave (
        .clk(clk), .rst_n(rst_n), .run_i(enable && !master),
        .bclk_in_i(bclk_in), .lrclk_in_i(lrclk_in),
        .bclk_o(s_bclk), .lrclk_o(s_lr), .rise_o(s_rise), .fall_o(s_fall)
    );

    // Mode selects the driving source and the pad enables.
    always_comb begin
        bclk_oe   = master;
        lrclk_oe  = master;
        bclk_o    = master ? m_bclk : s_bclk;
        lrclk_o   = master ? m_lr   : s_lr;
        bclk_rise = master ? m_rise : s_rise;
        bclk_fall = master ? m_fall : s_fall;
    end

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise && bclk_fall));
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (!bclk_o && !lrclk_o && !bclk_rise && !bclk_fall));
endmodule

// File: tb/tb_acg_clkgen.sv
module tb_acg_clkgen;
    logic clk = 1'b0, rst_n = 1'b0;
    logic enable = 0, master = 1, rclk_ext_sel = 0, rclk_ext_in = 0;
    logic [2:0] frame_code = 3'd0, bpf_code = 3'd2;
    logic bclk_in = 0, lrclk_in = 0;
    logic bclk_o, lrclk_o, bclk_oe, lrclk_oe, bclk_rise, bclk_fall, cfg_err;
    int checks = 0, errors = 0;
    bit ext_run = 0;

    always #5 clk = ~clk;

    acg_clkgen dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Disable, program codes, re-enable.
    task automatic setup(input logic [2:0] f, input logic [2:0] b, input logic m);
        @(negedge clk); enable = 0;
        cycles(3);
        frame_code = f; bpf_code = b; master = m;
        cycles(3);
        enable = 1;
    endtask

    // Cycles between two successive bit-clock rise strobes; also checks pulse shape.
    task automatic bclk_period(input string req, output int p);
        int g = 0;
        do begin @(negedge clk); g++; end while (!bclk_rise && g < 5000);
        check({req, " rise with bclk high"}, int'(bclk_o), 1);
        p = 0;
        do begin @(negedge clk); p++; end while (!bclk_rise && p < 5000);
    endtask

    // Cycles the frame clock stays at one level; every change must coincide with a fall strobe.
    task automatic lr_half(output int p);
        logic prev;
        int g = 0;
        prev = lrclk_o;
        do begin @(negedge clk); g++; end while (lrclk_o == prev && g < 5000);
        check("R11 lr change on fall", int'(bclk_fall), 1);
        prev = lrclk_o; p = 0;
        do begin @(negedge clk); p++; end while (lrclk_o == prev && p < 5000);
        check("R11 lr change on fall", int'(bclk_fall), 1);
    endtask

    task automatic wait_lr(input logic v);
        int g = 0;
        while (lrclk_o != v && g < 5000) begin @(negedge clk); g++; end
    endtask

    task automatic t_reset;
        cycles(3);
        check("R10 reset bclk", int'(bclk_o), 0);
        check("R10 reset lrclk", int'(lrclk_o), 0);
        @(negedge clk); rst_n = 1;
        cycles(10);
        check("R10 disabled bclk", int'(bclk_o), 0);
        check("R10 disabled strobe", int'(bclk_rise | bclk_fall), 0);
        check("R5 legal default no error", int'(cfg_err), 0);
    endtask

    task automatic t_frames;
        int p;
        setup(3'd1, 3'd0, 1'b1); bclk_period("R1", p); check("R1 384/16 period", p, 24);
        check("R6 master oe", int'(bclk_oe & lrclk_oe), 1);
        setup(3'd3, 3'd0, 1'b1); bclk_period("R1", p); check("R1 768/16 period", p, 48);
        setup(3'd2, 3'd2, 1'b1); bclk_period("R1", p); check("R1 512/32 period", p, 16);
        @(negedge clk);
        check("R9 rise one cycle", int'(bclk_rise), 0);
        setup(3'd6, 3'd0, 1'b1); bclk_period("R2", p); check("R2 fallback 256/16 period", p, 16);
    endtask

    task automatic t_bits;
        int p;
        setup(3'd1, 3'd3, 1'b1); lr_half(p); check("R3 384/48 lr half", p, 192);
        setup(3'd3, 3'd1, 1'b1); lr_half(p); check("R3 768/24 lr half", p, 384);
        setup(3'd0, 3'd0, 1'b1);
        cycles(2); bpf_code = 3'd5;
        bclk_period("R4", p); check("R4 bad bit code ignored", p, 16);
        lr_half(p); check("R4 lr half kept", p, 128);
    endtask

    task automatic t_illegal;
        int s = 0;
        setup(3'd0, 3'd1, 1'b1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            s += int'(bclk_o | lrclk_o | bclk_rise | bclk_fall);
        end
        check("R5 error flag", int'(cfg_err), 1);
        check("R5 clocks idle", s, 0);
    endtask

    task automatic t_change;
        int p;
        setup(3'd0, 3'd2, 1'b1);
        wait_lr(1'b1); wait_lr(1'b0);
        frame_code = 3'd2;
        bclk_period("R8", p); check("R8 old period before boundary", p, 8);
        wait_lr(1'b1); wait_lr(1'b0);
        bclk_period("R8", p); check("R8 new period after boundary", p, 16);
    endtask

    task automatic t_ext;
        int p;
        @(negedge clk); enable = 0; rclk_ext_sel = 1; ext_run = 1;
        setup(3'd0, 3'd2, 1'b1);
        bclk_period("R7", p); check("R7 external root period", p, 32);
        @(negedge clk); enable = 0; ext_run = 0; rclk_ext_sel = 0;
    endtask

    task automatic t_slave;
        setup(3'd0, 3'd2, 1'b0);
        cycles(4);
        check("R6 slave oe off", int'(bclk_oe | lrclk_oe), 0);
        bclk_in = 1; lrclk_in = 1;
        @(negedge clk); check("R6 slave delay 1", int'(bclk_o), 0);
        @(negedge clk); check("R6 slave bclk follows", int'(bclk_o), 1);
        check("R9 slave rise strobe", int'(bclk_rise), 1);
        check("R6 slave lrclk follows", int'(lrclk_o), 1);
        @(negedge clk); check("R9 slave rise one cycle", int'(bclk_rise), 0);
        bclk_in = 0;
        cycles(2); check("R9 slave fall strobe", int'(bclk_fall), 1);
    endtask

    // External root: toggles every 2 cycles, period 4 cycles.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (ext_run) begin
                c++;
                if (c == 2) begin rclk_ext_in = ~rclk_ext_in; c = 0; end
            end
        end
    end

    initial begin
        #1ms;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset;
        t_frames;
        t_bits;
        t_illegal;
        t_change;
        t_ext;
        t_slave;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule